// File: doc/BRIEF.md
# Periodic Self-Test Sequencer

This block sequences the built-in self-test of a cell-monitoring front end. A test is launched either by an external agent pulling a shared, active-low request line low, or on its own once a long run of measurement cycles has passed with no test. While the test runs, the block pulls the same line low itself, so that anything watching the line can see that a test is in progress.

A test walks through three checks in a fixed order. First comes a three-step comparator check against a secondary reference code: a narrow window, then an upper threshold set below the reference, then a lower threshold set above it. Next comes a multiplexer coverage check, based on whether any requested channel went unmeasured in the latest measurement cycle. Last, two ADC stimuli must return complementary alternating-bit words. The pass/fail result, a done pulse and a three-bit failure cause all change together on the final clock of the test. The result holds until the next test. Monitoring goes on after a failed test, and a fault status output stays active for as long as the result reads fail.

Top module: `selftest_seq`

## Requirements
- R1: When the synchronized request line goes from high to low while no test runs, a test starts: `req_pd_en` rises on the third rising clock edge after `req_n_in` first reads low.
- R2: With the default IDLE_LIMIT of 1024, a test starts on the 1024th `meas_strobe` counted since reset or since the last test start, whichever came later. Every test start, external or automatic, clears that count.
- R3: `req_pd_en` is high for the whole test and low otherwise. A test lasts exactly 5*SETTLE+1 clocks, which is 21 with the default SETTLE of 4.
- R4: After reset, `test_ok` is 1 and `done`, `fail_cause` and `req_pd_en` are 0.
- R5: `test_ok` goes to 0 after a failing test and back to 1 after a passing one. `fault_stat` is high whenever `test_ok` is 0 or `cell_alarm` is 1, and low otherwise.
- R6: The comparator check runs three steps of SETTLE clocks each. Step 0 sets lo=REF-WIN and hi=REF+WIN and expects neither over nor under. Step 1 sets hi=REF-WIN and lo=REF-2*WIN and expects over only. Step 2 sets lo=REF+WIN and hi=REF+2*WIN and expects under only. The comparator is sampled on the last clock of each step, and any mismatch sets `fail_cause[0]`.
- R7: On each `meas_strobe` the block records whether any bit set in `chan_req` is clear in `chan_seen`. If the record is set when the multiplexer step runs, `fail_cause[1]` is set.
- R8: The block applies stimulus 0 and then stimulus 1 (`adc_stim_sel`), each for SETTLE clocks. The expected words are: pattern 0 has bit i set for every even i (12'h555 at 12 bits), and pattern 1 is its complement (12'hAAA). A mismatch on either word sets `fail_cause[2]`.
- R9: A request that arrives while a test runs is ignored. It causes no second test.
- R10: `done` is a one-clock pulse. `test_ok` and `fail_cause` are updated on the same edge that raises `done` and drops `req_pd_en`, and `test_ok` is 1 exactly when `fail_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n_in | input | 1 | Level read back from the shared active-low request line |
| req_pd_en | output | 1 | Pull-down enable for the request line; high during a test |
| meas_strobe | input | 1 | One-clock pulse per measurement cycle |
| chan_req | input | CHAN_N | Channels requested in the current measurement cycle |
| chan_seen | input | CHAN_N | Channels actually measured in the current cycle |
| thr_hi | output | CODE_W | Upper comparator threshold |
| thr_lo | output | CODE_W | Lower comparator threshold |
| cmp_over | input | 1 | Comparator: reference above upper threshold |
| cmp_under | input | 1 | Comparator: reference below lower threshold |
| adc_stim_en | output | 1 | ADC test stimulus applied |
| adc_stim_sel | output | 1 | Stimulus select: 0 expects pattern 0, 1 expects pattern 1 |
| adc_word | input | ADC_W | ADC output word |
| cell_alarm | input | 1 | Alarm from the normal cell monitoring path |
| fault_stat | output | 1 | Fault status output |
| test_ok | output | 1 | Result of the last test (1 = pass) |
| done | output | 1 | One-clock pulse at the end of a test |
| fail_cause | output | 3 | Failure cause: bit0 comparator, bit1 multiplexer, bit2 ADC |

## Verification
The assertions assume that the request line is a wired-AND of the block's own pull-down and any external driver, so the line reads low whenever `req_pd_en` is high. They also assume that the comparator and ADC inputs settle within the SETTLE window after thresholds or stimulus change. The bench stays inside these assumptions. It models the line as exactly that wired-AND, derives the comparator outputs combinationally from `thr_hi`/`thr_lo` against a reference code that it controls, and returns ADC words combinationally from the stimulus select. Faults are injected only through that reference code, an XOR mask on the ADC word and a channel skip mask.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMP  = 2'd1,
      ST_MUX  = 2'd2,
      ST_ADC  = 2'd3
   } st_state_e;

   localparam int CAUSE_W   = 3;
   localparam int CAUSE_CMP = 0;
   localparam int CAUSE_MUX = 1;
   localparam int CAUSE_ADC = 2;

   localparam int CMP_STEPS = 3;
   localparam int ADC_STEPS = 2;

endpackage

// File: rtl/st_sync.sv
module st_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("st_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/st_idle_timer.sv
module st_idle_timer #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic hold,
   input  logic clear,
   output logic expire
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("st_idle_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clear)             cnt <= '0;
      else if (strobe && !hold)   cnt <= cnt + 1'b1;
   end

   assign expire = strobe && !hold && (cnt == LAST);

endmodule

// File: rtl/st_cmp_window.sv
module st_cmp_window #(
   parameter int CODE_W   = 12,
   parameter int REF_CODE = 2048,
   parameter int WIN      = 16
) (
   input  logic [1:0]        step,
   output logic [CODE_W-1:0] thr_hi,
   output logic [CODE_W-1:0] thr_lo,
   output logic              exp_over,
   output logic              exp_under
);

   localparam logic [CODE_W-1:0] BELOW2 = CODE_W'(REF_CODE - 2 * WIN);
   localparam logic [CODE_W-1:0] BELOW1 = CODE_W'(REF_CODE - WIN);
   localparam logic [CODE_W-1:0] ABOVE1 = CODE_W'(REF_CODE + WIN);
   localparam logic [CODE_W-1:0] ABOVE2 = CODE_W'(REF_CODE + 2 * WIN);

   generate
      if (WIN < 1) begin : g_bad_win
         $error("st_cmp_window: WIN must be positive");
      end
      if (REF_CODE - 2 * WIN < 0) begin : g_bad_low
         $error("st_cmp_window: window falls below code zero");
      end
      if (REF_CODE + 2 * WIN > (1 << CODE_W) - 1) begin : g_bad_high
         $error("st_cmp_window: window exceeds code range");
      end
   endgenerate

   always_comb begin
      case (step)
         2'd1: begin
            thr_lo    = BELOW2;
            thr_hi    = BELOW1;
            exp_over  = 1'b1;
            exp_under = 1'b0;
         end
         2'd2: begin
            thr_lo    = ABOVE1;
            thr_hi    = ABOVE2;
            exp_over  = 1'b0;
            exp_under = 1'b1;
         end
         default: begin
            thr_lo    = BELOW1;
            thr_hi    = ABOVE1;
            exp_over  = 1'b0;
            exp_under = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/st_pattern_chk.sv
module st_pattern_chk #(
   parameter int W = 12
) (
   input  logic [W-1:0] word,
   input  logic         sel,
   output logic         mismatch
);

   generate
      if (W < 2) begin : g_bad_w
         $error("st_pattern_chk: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] pat_even;

   for (genvar i = 0; i < W; i++) begin : g_pat
      assign pat_even[i] = ((i % 2) == 0);
   end

   assign mismatch = (word != (sel ? ~pat_even : pat_even));

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
   import selftest_pkg::*;
#(
   parameter int IDLE_LIMIT  = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE      = 4,
   parameter int CODE_W      = 12,
   parameter int REF_CODE    = 2048,
   parameter int WIN         = 16,
   parameter int CHAN_N      = 12,
   parameter int ADC_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_n_in,
   output logic              req_pd_en,
   input  logic              meas_strobe,
   input  logic [CHAN_N-1:0] chan_req,
   input  logic [CHAN_N-1:0] chan_seen,
   output logic [CODE_W-1:0] thr_hi,
   output logic [CODE_W-1:0] thr_lo,
   input  logic              cmp_over,
   input  logic              cmp_under,
   output logic              adc_stim_en,
   output logic              adc_stim_sel,
   input  logic [ADC_W-1:0]  adc_word,
   input  logic              cell_alarm,
   output logic              fault_stat,
   output logic              test_ok,
   output logic              done,
   output logic [CAUSE_W-1:0] fail_cause
);

   localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
   localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);
   localparam logic [1:0] CMP_LAST_STEP = 2'(CMP_STEPS - 1);

   generate
      if (SETTLE < 1) begin : g_bad_settle
         $error("selftest_seq: SETTLE must be at least 1");
      end
      if (CHAN_N < 1) begin : g_bad_chan
         $error("selftest_seq: CHAN_N must be at least 1");
      end
   endgenerate

   // request line synchronizer and falling-edge detect
   logic req_s;
   logic req_prev;
   logic ext_fall;

   st_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_n_in),
      .q     (req_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= 1'b1;
      else        req_prev <= req_s;
   end

   assign ext_fall = req_prev && !req_s;

   // sequencer state
   st_state_e         state;
   logic [1:0]        step;
   logic [SW-1:0]     settle;
   logic [CAUSE_W-1:0] cause_acc;
   logic              busy;
   logic              start;
   logic              auto_go;
   logic              last_settle;

   assign busy        = (state != ST_IDLE);
   assign last_settle = (settle == SETTLE_LAST);
   assign start       = !busy && (ext_fall || auto_go);

   st_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (meas_strobe),
      .hold   (busy),
      .clear  (start),
      .expire (auto_go)
   );

   // comparator threshold table
   logic exp_over;
   logic exp_under;
   logic cmp_bad;

   st_cmp_window #(
      .CODE_W   (CODE_W),
      .REF_CODE (REF_CODE),
      .WIN      (WIN)
   ) u_win (
      .step      (step),
      .thr_hi    (thr_hi),
      .thr_lo    (thr_lo),
      .exp_over  (exp_over),
      .exp_under (exp_under)
   );

   assign cmp_bad = (cmp_over != exp_over) || (cmp_under != exp_under);

   // multiplexer coverage record, refreshed every measurement cycle
   logic skip_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           skip_seen <= 1'b0;
      else if (meas_strobe) skip_seen <= |(chan_req & ~chan_seen);
   end

   // ADC pattern checker
   logic adc_bad;

   st_pattern_chk #(.W(ADC_W)) u_pat (
      .word     (adc_word),
      .sel      (step[0]),
      .mismatch (adc_bad)
   );

   assign adc_stim_en  = (state == ST_ADC);
   assign adc_stim_sel = (state == ST_ADC) && step[0];

   // final cause vector on the closing clock
   logic [CAUSE_W-1:0] cause_final;

   always_comb begin
      cause_final = cause_acc;
      cause_final[CAUSE_ADC] = cause_acc[CAUSE_ADC] | adc_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         step       <= 2'd0;
         settle     <= '0;
         cause_acc  <= '0;
         done       <= 1'b0;
         test_ok    <= 1'b1;
         fail_cause <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state     <= ST_CMP;
                  step      <= 2'd0;
                  settle    <= '0;
                  cause_acc <= '0;
               end
            end
            ST_CMP: begin
               if (last_settle) begin
                  settle <= '0;
                  if (cmp_bad) cause_acc[CAUSE_CMP] <= 1'b1;
                  if (step == CMP_LAST_STEP) begin
                     state <= ST_MUX;
                     step  <= 2'd0;
                  end else begin
                     step <= step + 2'd1;
                  end
               end else begin
                  settle <= settle + 1'b1;
               end
            end
            ST_MUX: begin
               if (skip_seen) cause_acc[CAUSE_MUX] <= 1'b1;
               state  <= ST_ADC;
               step   <= 2'd0;
               settle <= '0;
            end
            ST_ADC: begin
               if (last_settle) begin
                  settle <= '0;
                  if (step[0] == 1'b0) begin
                     if (adc_bad) cause_acc[CAUSE_ADC] <= 1'b1;
                     step <= 2'd1;
                  end else begin
                     state      <= ST_IDLE;
                     step       <= 2'd0;
                     done       <= 1'b1;
                     fail_cause <= cause_final;
                     test_ok    <= (cause_final == '0);
                  end
               end else begin
                  settle <= settle + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_pd_en  = busy;
   assign fault_stat = cell_alarm || !test_ok;

endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_pd_en,
   input logic              done,
   input logic              test_ok,
   input logic [2:0]        fail_cause,
   input logic              adc_stim_en,
   input logic [CODE_W-1:0] thr_hi,
   input logic [CODE_W-1:0] thr_lo
);

   // R10: done lasts one clock
   a_r10_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10/R3: done coincides with the end of the pull-down
   a_r10_done_ends_test : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!req_pd_en && $past(req_pd_en)));

   // R5: the result only moves on a done pulse
   a_r5_ok_moves_on_done : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(test_ok) |-> done);

   // R10: pass flag agrees with the cause vector
   a_r10_cause_agrees : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (test_ok == (fail_cause == 3'b000)));

   // R8: stimulus only inside a test
   a_r8_stim_in_test : assert property (@(posedge clk) disable iff (!rst_n)
      adc_stim_en |-> req_pd_en);

   // R6: thresholds always ordered
   a_r6_thr_ordered : assert property (@(posedge clk) disable iff (!rst_n)
      req_pd_en |-> (thr_lo < thr_hi));

endmodule

bind selftest_seq selftest_seq_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_pd_en   (req_pd_en),
   .done        (done),
   .test_ok     (test_ok),
   .fail_cause  (fail_cause),
   .adc_stim_en (adc_stim_en),
   .thr_hi      (thr_hi),
   .thr_lo      (thr_lo)
);

// File: tb/tb_selftest_seq.sv
module tb_selftest_seq;

   localparam int CODE_W   = 12;
   localparam int ADC_W    = 12;
   localparam int CHAN_N   = 12;
   localparam int REF_CODE = 2048;
   localparam int WIN      = 16;
   localparam int SETTLE   = 4;
   localparam int TEST_LEN = 5 * SETTLE + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              ext_low = 1'b0;
   logic              req_pd_en;
   logic              meas_strobe = 1'b0;
   logic [CHAN_N-1:0] chan_req = '1;
   logic [CHAN_N-1:0] skip_mask = '0;
   logic [CHAN_N-1:0] chan_seen;
   logic [CODE_W-1:0] thr_hi, thr_lo;
   logic              cmp_over, cmp_under;
   logic              adc_stim_en, adc_stim_sel;
   logic [ADC_W-1:0]  adc_word;
   logic [ADC_W-1:0]  adc_flip = '0;
   logic              cell_alarm = 1'b0;
   logic              fault_stat, test_ok, done;
   logic [2:0]        fail_cause;
   logic              req_line;
   int                ref_code = REF_CODE;

   // environment models
   assign req_line  = !(req_pd_en || ext_low);
   assign chan_seen = chan_req & ~skip_mask;
   assign cmp_over  = (ref_code > int'(thr_hi));
   assign cmp_under = (ref_code < int'(thr_lo));
   assign adc_word  = adc_stim_en ?
                      ((adc_stim_sel ? 12'hAAA : 12'h555) ^ adc_flip) : '0;

   selftest_seq dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_n_in     (req_line),
      .req_pd_en    (req_pd_en),
      .meas_strobe  (meas_strobe),
      .chan_req     (chan_req),
      .chan_seen    (chan_seen),
      .thr_hi       (thr_hi),
      .thr_lo       (thr_lo),
      .cmp_over     (cmp_over),
      .cmp_under    (cmp_under),
      .adc_stim_en  (adc_stim_en),
      .adc_stim_sel (adc_stim_sel),
      .adc_word     (adc_word),
      .cell_alarm   (cell_alarm),
      .fault_stat   (fault_stat),
      .test_ok      (test_ok),
      .done         (done),
      .fail_cause   (fail_cause)
   );

   int checks = 0;
   int errors = 0;
   int done_seen = 0;
   int busy_cycles = 0;
   bit finished = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (req_pd_en) busy_cycles++;
         if (done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected test completion", 1, 0);
            end else begin
               logic [2:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(fail_cause == e, t, "fail_cause", int'(fail_cause), int'(e));
               check(test_ok == (e == 3'b000), "R5", "test_ok at done",
                     int'(test_ok), int'(e == 3'b000));
               check(!req_pd_en, "R10", "pull-down dropped with done",
                     int'(req_pd_en), 0);
            end
            check(busy_cycles == TEST_LEN, "R3", "test length",
                  busy_cycles, TEST_LEN);
            busy_cycles = 0;
         end
      end
   end

   task automatic expect_result(input logic [2:0] cause, input string tag);
      exp_q.push_back(cause);
      tag_q.push_back(tag);
   endtask

   // external request; checks start latency (R1)
   task automatic ext_test(input logic [2:0] cause, input string tag);
      int n;
      n = done_seen;
      expect_result(cause, tag);
      @(negedge clk);
      ext_low = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(!req_pd_en, "R1", "no start before third edge", int'(req_pd_en), 0);
      @(negedge clk);
      check(req_pd_en, "R1", "start on third edge", int'(req_pd_en), 1);
      @(negedge clk);
      ext_low = 1'b0;
      wait (done_seen == n + 1);
      @(negedge clk);
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         meas_strobe = 1'b1;
         @(negedge clk);
         meas_strobe = 1'b0;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 reset state
      check(test_ok == 1'b1, "R4", "test_ok after reset", int'(test_ok), 1);
      check(done == 1'b0, "R4", "done after reset", int'(done), 0);
      check(fail_cause == 3'b000, "R4", "fail_cause after reset", int'(fail_cause), 0);
      check(req_pd_en == 1'b0, "R4", "pull-down after reset", int'(req_pd_en), 0);
      check(fault_stat == 1'b0, "R5", "fault_stat idle", int'(fault_stat), 0);

      // passing external test
      ext_test(3'b000, "R1");

      // R6 comparator fault: reference shifted just above window
      ref_code = REF_CODE + WIN + 1;
      ext_test(3'b001, "R6");
      ref_code = REF_CODE;
      check(fault_stat == 1'b1, "R5", "fault_stat after fail", int'(fault_stat), 1);

      // R6 comparator fault: reference inside the step-1 window
      ref_code = REF_CODE - WIN;
      ext_test(3'b001, "R6");
      ref_code = REF_CODE;

      // R7 multiplexer skip
      skip_mask = 12'h010;
      strobes(1);
      skip_mask = '0;
      ext_test(3'b010, "R7");

      // R7 record refreshed by a clean cycle
      strobes(1);
      ext_test(3'b000, "R7");
      check(test_ok == 1'b1, "R5", "test_ok restored", int'(test_ok), 1);
      check(fault_stat == 1'b0, "R5", "fault_stat cleared", int'(fault_stat), 0);

      // R8 ADC stuck bit
      adc_flip = 12'h008;
      ext_test(3'b100, "R8");
      adc_flip = '0;

      // combined faults
      ref_code = REF_CODE + WIN + 1;
      adc_flip = 12'h800;
      ext_test(3'b101, "R8");
      ref_code = REF_CODE;
      adc_flip = '0;

      // R5 cell alarm drives fault status while passing
      ext_test(3'b000, "R5");
      cell_alarm = 1'b1;
      @(negedge clk);
      check(fault_stat == 1'b1, "R5", "fault_stat with cell alarm", int'(fault_stat), 1);
      cell_alarm = 1'b0;
      @(negedge clk);
      check(fault_stat == 1'b0, "R5", "fault_stat alarm removed", int'(fault_stat), 0);

      // R9 request while busy is ignored
      begin
         int n;
         n = done_seen;
         expect_result(3'b000, "R9");
         @(negedge clk);
         ext_low = 1'b1;
         repeat (4) @(negedge clk);
         ext_low = 1'b0;
         repeat (5) @(negedge clk);
         ext_low = 1'b1;
         repeat (3) @(negedge clk);
         ext_low = 1'b0;
         wait (done_seen == n + 1);
         repeat (40) @(negedge clk);
         check(done_seen == n + 1, "R9", "test count after busy request", done_seen, n + 1);
         check(!req_pd_en, "R9", "no second test", int'(req_pd_en), 0);
      end

      // R2 automatic trigger after 1024 strobes
      strobes(1023);
      check(!req_pd_en, "R2", "no test at 1023 strobes", int'(req_pd_en), 0);
      expect_result(3'b000, "R2");
      strobes(1);
      check(req_pd_en, "R2", "auto test on 1024th strobe", int'(req_pd_en), 1);
      wait (busy_cycles == 0 && !req_pd_en);
      repeat (4) @(negedge clk);

      // R2 an external test clears the idle count
      strobes(600);
      ext_test(3'b000, "R2");
      strobes(1023);
      check(!req_pd_en, "R2", "count cleared by external start", int'(req_pd_en), 0);
      expect_result(3'b000, "R2");
      strobes(1);
      check(req_pd_en, "R2", "auto test after clear", int'(req_pd_en), 1);
      wait (!req_pd_en);
      repeat (4) @(negedge clk);

      check(exp_q.size() == 0, "R10", "all expected results seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule